// File: doc/BRIEF.md
# SPI One-Time-Programmable Security Register Engine

This block is the slave side of a serial-flash-style SPI link that serves three one-time-programmable security registers of 512 bytes each, held in on-chip RAM. A host selects the device with an active-low chip select and clocks in an opcode, a 24-bit address and then either data bytes to program or a dummy byte before read data. Programming is one-time in nature: a stored bit can only move from 1 to 0.

The SPI pins are oversampled in the system clock domain. Program data goes first into a page buffer. When chip select rises cleanly after a valid program frame, a self-timed program cycle starts. During this cycle a busy flag is high. A walker merges every buffered byte into the target register, and the write-enable flag is cleared. The write-enable flag is set by a single input strobe. Per-register lock inputs make a register permanently read-only.

Top module: `sec_reg_spi_slave`

## Requirements
- R1: After reset, `wip`, `wel` and `so` are all 0, and every stored byte reads 0xFF.
- R2: A one-clock pulse on `wel_set` while `wip` is 0 sets `wel`. A pulse while `wip` is 1 is ignored. Starting a program cycle clears `wel`, and `wel` stays 0 for the whole cycle.
- R3: A program frame is opcode 0x42, then three address bytes, then at least one data byte, all MSB first and sampled on SCLK rising edges. If it is accepted, `wip` rises after chip select goes high and stays 1 for exactly `TPP_CLKS` system clocks (raised to REG_BYTES+4 if set lower). A frame with no data byte starts nothing.
- R4: A program frame sent while `wel` is 0 starts no cycle and changes no data.
- R5: Address bits [23:16] and [11:9] must be 0. Field [15:12] equal to 1, 2 or 3 selects register 1, 2 or 3, and bits [8:0] give the byte offset. Any other address makes a program do nothing (no cycle) and makes every read byte 0xFF.
- R6: If `lock_bits[k]` is 1, a program aimed at register k+1 starts no cycle and leaves the register unchanged.
- R7: Programming stores old AND new, so a second program to the same byte can only clear bits.
- R8: During a program, the offset wraps from 0x1FF to 0x000 inside the same register. Only the last byte sent to each offset is merged.
- R9: If chip select rises when a byte is only partly shifted in, the program is aborted: no cycle starts and no data changes.
- R10: A read frame is opcode 0x48, three address bytes and one dummy byte. Data bits are then driven on `so` on SCLK falling edges, MSB first, so the first data bit is valid before the first rising edge that follows the dummy byte.
- R11: During a read, the offset advances after each byte and wraps from 0x1FF to 0x000 inside the same register until chip select rises.
- R12: Any frame whose chip select falls while `wip` is 1 is ignored: a read returns only 0 bits and a program has no effect.
- R13: `so` is 0 except while read data is being shifted out. It is therefore 0 during the opcode, address and dummy bytes and throughout program frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI serial clock |
| si | input | 1 | SPI serial data in |
| so | output | 1 | SPI serial data out |
| wel_set | input | 1 | One-clock strobe that sets the write-enable flag |
| lock_bits | input | NUM_REGS | Permanent lock per register, bit k for register k+1 |
| wip | output | 1 | Program cycle in progress |
| wel | output | 1 | Write-enable flag |

## Verification
The assertions take for granted the following about the inputs:
- Each SCLK level lasts several system clocks, so the oversampling front end sees every edge.
- Chip select stays high for a few clocks between frames.
- The lock inputs do not change while a program cycle runs.

The bench keeps within these limits. It holds each SCLK level for five system clocks and waits several clocks after every chip-select rise. It changes `lock_bits` only while the block is idle. Under these conditions the properties on busy-cycle length, write-enable clearing, writes to locked registers and a quiet `so` are meaningful. Outside them, edges can be missed.

// File: rtl/sec_reg_pkg.sv
package sec_reg_pkg;
  localparam logic [7:0] OP_PROG = 8'h42;
  localparam logic [7:0] OP_READ = 8'h48;
  localparam logic [2:0] HDR_DONE = 3'd4;  // opcode + 3 address bytes received
endpackage

// File: rtl/sec_spi_sync.sv
module sec_spi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sclk,
  input  logic si,
  output logic cs_n_q,
  output logic cs_fall,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_q
);
  logic [STAGES:0] cs_p;
  logic [STAGES:0] ck_p;
  logic [STAGES:0] si_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_p <= '1;
      ck_p <= '0;
      si_p <= '0;
    end else begin
      cs_p <= {cs_p[STAGES-1:0], cs_n};
      ck_p <= {ck_p[STAGES-1:0], sclk};
      si_p <= {si_p[STAGES-1:0], si};
    end
  end

  assign cs_n_q   = cs_p[STAGES-1];
  assign cs_fall  = cs_p[STAGES] & ~cs_p[STAGES-1];
  assign cs_rise  = ~cs_p[STAGES] & cs_p[STAGES-1];
  assign sck_rise = ~ck_p[STAGES] & ck_p[STAGES-1];
  assign sck_fall = ck_p[STAGES] & ~ck_p[STAGES-1];
  assign si_q     = si_p[STAGES-1];
endmodule

// File: rtl/sec_sdp_ram.sv
module sec_sdp_ram #(
  parameter int          W     = 8,
  parameter int          DEPTH = 512,
  parameter int          AW    = 9,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = INIT;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sec_reg_spi_slave.sv
module sec_reg_spi_slave
  import sec_reg_pkg::*;
#(
  parameter int NUM_REGS    = 3,
  parameter int REG_BYTES   = 512,
  parameter int TPP_CLKS    = 600,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_n,
  input  logic                sclk,
  input  logic                si,
  output logic                so,
  input  logic                wel_set,
  input  logic [NUM_REGS-1:0] lock_bits,
  output logic                wip,
  output logic                wel
);
  localparam int OFF_W     = $clog2(REG_BYTES);
  localparam int SEL_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int MEM_DEPTH = NUM_REGS * REG_BYTES;
  localparam int MEM_AW    = SEL_W + OFF_W;
  localparam int TPP_EFF   = (TPP_CLKS > REG_BYTES + 4) ? TPP_CLKS : REG_BYTES + 4;
  localparam int TMR_W     = $clog2(TPP_EFF + 1);
  localparam logic [OFF_W:0] WALK_END = (OFF_W+1)'(REG_BYTES);

  // synchronized pin events
  logic cs_n_q, cs_fall, cs_rise, sck_rise, sck_fall, si_q;

  sec_spi_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .si(si),
    .cs_n_q(cs_n_q), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .si_q(si_q)
  );

  // frame state
  logic                 frm_act;
  logic [2:0]           bit_cnt;
  logic [2:0]           byte_cnt;
  logic [7:0]           shreg;
  logic [7:0]           opcode;
  logic [15:0]          addr_hi;
  logic                 addr_ok;
  logic [SEL_W-1:0]     reg_sel;
  logic [OFF_W-1:0]     off;
  logic                 got_data;
  logic [REG_BYTES-1:0] valid_vec;
  logic                 rd_phase;
  logic [7:0]           out_sr;
  logic [2:0]           out_cnt;

  // program engine state
  logic [TMR_W-1:0]     tmr;
  logic [OFF_W:0]       walk;
  logic                 p_v;
  logic [OFF_W-1:0]     p_off;

  // memories
  logic                 mem_we;
  logic [MEM_AW-1:0]    mem_waddr, mem_raddr;
  logic [7:0]           mem_wdata, mem_rdata;
  logic                 buf_we;
  logic [7:0]           buf_rdata;

  // byte assembly and address decode
  logic             byte_fire;
  logic [7:0]       rx_byte;
  logic [23:0]      full_addr;
  logic [3:0]       fld;
  logic             dec_ok;
  logic [SEL_W-1:0] dec_sel;
  logic [7:0]       rd_byte;
  logic             prog_go;

  assign byte_fire = frm_act && !cs_n_q && sck_rise && (bit_cnt == 3'd7);
  assign rx_byte   = {shreg[6:0], si_q};
  assign full_addr = {addr_hi, rx_byte};
  assign fld       = full_addr[15:12];
  assign dec_ok    = (full_addr[23:16] == 8'h00) &&
                     ((full_addr[11:0] >> OFF_W) == 12'd0) &&
                     (fld != 4'd0) && (int'(fld) <= NUM_REGS);
  assign dec_sel   = dec_ok ? SEL_W'(fld - 4'd1) : '0;
  assign rd_byte   = addr_ok ? mem_rdata : 8'hFF;

  assign buf_we = byte_fire && (byte_cnt == HDR_DONE) && (opcode == OP_PROG);

  assign prog_go = cs_rise && frm_act && (opcode == OP_PROG) &&
                   (byte_cnt == HDR_DONE) && got_data && (bit_cnt == 3'd0) &&
                   addr_ok && !lock_bits[reg_sel] && wel;

  // frame decoder, read shifter
  always_ff @(posedge clk) begin
    if (rst) begin
      frm_act   <= 1'b0;
      bit_cnt   <= '0;
      byte_cnt  <= '0;
      shreg     <= '0;
      opcode    <= '0;
      addr_hi   <= '0;
      addr_ok   <= 1'b0;
      reg_sel   <= '0;
      off       <= '0;
      got_data  <= 1'b0;
      valid_vec <= '0;
      rd_phase  <= 1'b0;
      out_sr    <= '0;
      out_cnt   <= '0;
      so        <= 1'b0;
    end else begin
      if (cs_fall) begin
        frm_act  <= !wip;
        bit_cnt  <= '0;
        byte_cnt <= '0;
        opcode   <= '0;
        got_data <= 1'b0;
        rd_phase <= 1'b0;
        out_cnt  <= '0;
        if (!wip) valid_vec <= '0;
      end else if (cs_n_q) begin
        frm_act  <= 1'b0;
        rd_phase <= 1'b0;
        so       <= 1'b0;
      end

      if (frm_act && !cs_n_q && sck_rise) begin
        shreg   <= rx_byte;
        bit_cnt <= bit_cnt + 3'd1;
      end

      if (byte_fire) begin
        if (byte_cnt != HDR_DONE) byte_cnt <= byte_cnt + 3'd1;
        case (byte_cnt)
          3'd0: opcode        <= rx_byte;
          3'd1: addr_hi[15:8] <= rx_byte;
          3'd2: addr_hi[7:0]  <= rx_byte;
          3'd3: begin
            addr_ok <= dec_ok;
            reg_sel <= dec_sel;
            off     <= full_addr[OFF_W-1:0];
          end
          default: begin
            if (opcode == OP_READ) begin
              rd_phase <= 1'b1;
            end else if (opcode == OP_PROG) begin
              valid_vec[off] <= 1'b1;
              off            <= off + 1'b1;
              got_data       <= 1'b1;
            end
          end
        endcase
      end

      if (rd_phase && !cs_n_q && sck_fall) begin
        if (out_cnt == 3'd0) begin
          so      <= rd_byte[7];
          out_sr  <= {rd_byte[6:0], 1'b0};
          out_cnt <= 3'd7;
          off     <= off + 1'b1;
        end else begin
          so      <= out_sr[7];
          out_sr  <= {out_sr[6:0], 1'b0};
          out_cnt <= out_cnt - 3'd1;
        end
      end
    end
  end

  // self-timed program cycle and commit walker
  always_ff @(posedge clk) begin
    if (rst) begin
      wip   <= 1'b0;
      wel   <= 1'b0;
      tmr   <= '0;
      walk  <= WALK_END;
      p_v   <= 1'b0;
      p_off <= '0;
    end else begin
      if (prog_go) begin
        wip  <= 1'b1;
        wel  <= 1'b0;
        tmr  <= '0;
        walk <= '0;
      end else if (wip) begin
        tmr <= tmr + 1'b1;
        if (tmr == TMR_W'(TPP_EFF - 1)) wip <= 1'b0;
        if (walk != WALK_END) walk <= walk + 1'b1;
      end else if (wel_set) begin
        wel <= 1'b1;
      end
      p_v   <= wip && (walk != WALK_END) && valid_vec[walk[OFF_W-1:0]];
      p_off <= walk[OFF_W-1:0];
    end
  end

  assign mem_raddr = wip ? {reg_sel, walk[OFF_W-1:0]} : {reg_sel, off};
  assign mem_we    = p_v;
  assign mem_waddr = {reg_sel, p_off};
  assign mem_wdata = mem_rdata & buf_rdata;

  sec_sdp_ram #(.W(8), .DEPTH(MEM_DEPTH), .AW(MEM_AW), .INIT(8'hFF)) store_i (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  sec_sdp_ram #(.W(8), .DEPTH(REG_BYTES), .AW(OFF_W), .INIT(8'hFF)) page_i (
    .clk(clk), .we(buf_we), .waddr(off), .wdata(rx_byte),
    .raddr(walk[OFF_W-1:0]), .rdata(buf_rdata)
  );
endmodule

// File: rtl/sec_reg_chk.sv
module sec_reg_chk #(
  parameter int TPP_EFF  = 600,
  parameter int NUM_REGS = 3,
  parameter int SEL_W    = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                cs_n,
  input logic                so,
  input logic                wip,
  input logic                wel,
  input logic                mem_we,
  input logic [NUM_REGS-1:0] lock_bits,
  input logic [SEL_W-1:0]    reg_sel
);
  int unsigned hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) hi_cnt <= 0;
    else if (wip) hi_cnt <= hi_cnt + 1;
    else hi_cnt <= 0;
  end

  assert_wel_clear_in_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    wip |-> !wel);

  assert_cycle_length_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(wip) |-> (hi_cnt == TPP_EFF));

  assert_start_after_deselect_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(wip) |-> cs_n);

  assert_locked_untouched_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (wip && !lock_bits[reg_sel]));

  assert_so_quiet_deselected_R13: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !so);
endmodule

bind sec_reg_spi_slave sec_reg_chk #(
  .TPP_EFF(TPP_EFF), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)
) chk_i (
  .clk(clk), .rst(rst), .cs_n(cs_n), .so(so), .wip(wip), .wel(wel),
  .mem_we(mem_we), .lock_bits(lock_bits), .reg_sel(reg_sel)
);

// File: tb/sec_reg_spi_slave_tb.sv
`timescale 1ns/1ps
module sec_reg_spi_slave_tb_top;
  localparam int HALF = 5;
  localparam int TPP  = 600;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, si = 1'b0, wel_set = 1'b0;
  logic [2:0] lock_bits = 3'b000;
  logic so, wip, wel;

  always #10 clk = ~clk;  // 50 MHz

  sec_reg_spi_slave #(.NUM_REGS(3), .REG_BYTES(512), .TPP_CLKS(TPP)) dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .si(si), .so(so),
    .wel_set(wel_set), .lock_bits(lock_bits), .wip(wip), .wel(wel)
  );

  int vectors = 0;
  int errors  = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  logic [7:0] model [3][512];
  int run_len = 0;
  int last_len = 0;

  always @(negedge clk) begin
    if (wip) run_len <= run_len + 1;
    else if (run_len != 0) begin
      last_len <= run_len;
      run_len  <= 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic spi_frame(input int nbits);
    logic [7:0] cur = '0;
    rxq.delete();
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      si = txq[i/8][7-(i%8)];
      repeat (HALF) @(negedge clk);
      cur[7-(i%8)] = so;
      if ((i % 8) == 7) rxq.push_back(cur);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic push_hdr(input logic [7:0] op, input logic [23:0] a);
    txq.delete();
    txq.push_back(op);
    txq.push_back(a[23:16]);
    txq.push_back(a[15:8]);
    txq.push_back(a[7:0]);
  endtask

  function automatic logic [23:0] reg_addr(input int r, input int o);
    return {8'h00, 4'(r + 1), 12'(o)};
  endfunction

  task automatic read_block(input logic [23:0] a, input int n);
    push_hdr(8'h48, a);
    for (int k = 0; k < n + 1; k++) txq.push_back(8'h00);
    spi_frame((5 + n) * 8);
  endtask

  task automatic verify(input string req, input int r, input int start, input int n);
    read_block(reg_addr(r, start), n);
    for (int k = 0; k < 5; k++) chk("R13 header quiet", 32'(rxq[k]), 32'h0);
    for (int k = 0; k < n; k++)
      chk(req, 32'(rxq[5 + k]), 32'(model[r][(start + k) % 512]));
  endtask

  task automatic set_wel();
    @(negedge clk) wel_set = 1'b1;
    @(negedge clk) wel_set = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    int g = 0;
    while (wip && g < 5000) begin
      @(negedge clk);
      g++;
    end
    repeat (4) @(negedge clk);
  endtask

  // commits a model program with last-write-wins then AND merge
  task automatic model_prog(input int r, input int start, input int n);
    logic [7:0] pend [512];
    logic       pv [512];
    for (int k = 0; k < 512; k++) pv[k] = 1'b0;
    for (int k = 0; k < n; k++) begin
      pend[(start + k) % 512] = txq[4 + k];
      pv[(start + k) % 512]   = 1'b1;
    end
    for (int k = 0; k < 512; k++) if (pv[k]) model[r][k] = model[r][k] & pend[k];
  endtask

  task automatic accepted_prog(input string req, input int r, input int start, input int n);
    spi_frame((4 + n) * 8);
    for (int k = 0; k < rxq.size(); k++) chk("R13 prog quiet", 32'(rxq[k]), 32'h0);
    chk({req, " wip up"}, 32'(wip), 32'h1);
    chk("R2 wel cleared", 32'(wel), 32'h0);
    model_prog(r, start, n);
    wait_idle();
    chk("R3 busy length", 32'(last_len), 32'(TPP));
  endtask

  initial begin
    repeat (100000 * 2 - 10000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int r = 0; r < 3; r++)
      for (int k = 0; k < 512; k++) model[r][k] = 8'hFF;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R1
    chk("R1 wip", 32'(wip), 32'h0);
    chk("R1 wel", 32'(wel), 32'h0);
    chk("R1 so", 32'(so), 32'h0);
    verify("R1 erased", 0, 0, 4);

    // R4: no write enable
    push_hdr(8'h42, reg_addr(0, 16));
    txq.push_back(8'h00);
    spi_frame(40);
    chk("R4 no cycle", 32'(wip), 32'h0);
    verify("R4 unchanged", 0, 16, 1);

    // R2 set
    set_wel();
    chk("R2 wel set", 32'(wel), 32'h1);

    // R3 + R10: basic program and read back
    push_hdr(8'h42, reg_addr(0, 16));
    txq.push_back(8'hA5);
    txq.push_back(8'h3C);
    accepted_prog("R3", 0, 16, 2);
    verify("R10 read data", 0, 14, 4);

    // R7: AND merge
    set_wel();
    push_hdr(8'h42, reg_addr(0, 16));
    txq.push_back(8'h5A);
    accepted_prog("R7", 0, 16, 1);
    verify("R7 and merge", 0, 16, 2);

    // R8 + R11: program wrap in reg 2, read wrap
    set_wel();
    push_hdr(8'h42, reg_addr(1, 510));
    txq.push_back(8'h11); txq.push_back(8'h22);
    txq.push_back(8'h44); txq.push_back(8'h88);
    accepted_prog("R8", 1, 510, 4);
    verify("R11 read wrap", 1, 508, 8);

    // R8: long program in reg 3, last write per offset wins
    set_wel();
    push_hdr(8'h42, reg_addr(2, 5));
    for (int k = 0; k < 514; k++) txq.push_back(8'((k * 37 + 11) & 8'hFF));
    accepted_prog("R8 long", 2, 5, 514);
    verify("R8 last write", 2, 0, 516);

    // R6: locked register 2
    lock_bits = 3'b010;
    set_wel();
    push_hdr(8'h42, reg_addr(1, 510));
    txq.push_back(8'h00);
    spi_frame(40);
    chk("R6 no cycle", 32'(wip), 32'h0);
    chk("R6 wel kept", 32'(wel), 32'h1);
    verify("R6 unchanged", 1, 510, 2);

    // R5: invalid addresses
    push_hdr(8'h42, 24'h004030);
    txq.push_back(8'h00);
    spi_frame(40);
    chk("R5 bad field no cycle", 32'(wip), 32'h0);
    push_hdr(8'h42, 24'h001230);
    txq.push_back(8'h00);
    spi_frame(40);
    chk("R5 reserved bits no cycle", 32'(wip), 32'h0);
    verify("R5 no alias write", 0, 48, 1);
    read_block(24'h001230, 2);
    chk("R5 read ff 0", 32'(rxq[5]), 32'hFF);
    chk("R5 read ff 1", 32'(rxq[6]), 32'hFF);
    read_block(24'h011010, 1);
    chk("R5 high byte ff", 32'(rxq[5]), 32'hFF);

    // R9: partial byte abort, and R3 header-only frame
    push_hdr(8'h42, reg_addr(0, 64));
    txq.push_back(8'h00);
    spi_frame(37);
    chk("R9 no cycle", 32'(wip), 32'h0);
    push_hdr(8'h42, reg_addr(0, 64));
    spi_frame(32);
    chk("R3 no data no cycle", 32'(wip), 32'h0);
    verify("R9 unchanged", 0, 64, 1);

    // R12: traffic during busy
    push_hdr(8'h42, reg_addr(0, 80));
    txq.push_back(8'h0F);
    spi_frame(40);
    model_prog(0, 80, 1);
    chk("R12 busy", 32'(wip), 32'h1);
    read_block(reg_addr(0, 16), 1);
    for (int k = 0; k < rxq.size(); k++) chk("R12 read ignored", 32'(rxq[k]), 32'h0);
    chk("R12 still busy", 32'(wip), 32'h1);
    set_wel();
    chk("R2 set ignored when busy", 32'(wel), 32'h0);
    wait_idle();
    chk("R3 busy length", 32'(last_len), 32'(TPP));
    verify("R12 committed", 0, 80, 1);
    set_wel();
    chk("R2 set when idle", 32'(wel), 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule